// File: doc/BRIEF.md
# Floating-Point Flags Word Generator

This unit inspects two IEEE-754 double-precision operands together with an operation select (add, subtract or multiply) and condenses everything the later mantissa stages of a multi-step floating-point datapath need into one 64-bit flags word. The word holds the full set of IEEE comparison relations between operand A and operand B, the sign the result will carry, a preliminary biased exponent, and an effective-operation bit. That bit tells the mantissa adder whether it must add or subtract the aligned magnitudes.

The logic is purely combinational. A parameter selects whether the word leaves through an output register (the default, one cycle of latency) or straight from the logic. The unit does not compute the arithmetic result and keeps no exception or status state.

Top module: `fpflag_gen`

## Requirements
- R1: The flags word places the exponent in bits 17..7, the sign at bit 20, the effective-operation bit at bit 21, unordered at 25, lt at 26, le at 27, gt at 28, ge at 29, eq at 30 and neq at 31. Every other bit is zero.
- R2: When neither operand is NaN, exactly one of eq and neq is set. eq is set when A equals B numerically, and positive zero equals negative zero.
- R3: An operand is NaN when its exponent field is all ones and its fraction is non-zero. If either operand is NaN, unordered and neq are set and eq, lt, le, gt and ge are clear.
- R4: For operands that are not NaN, lt, le, gt and ge give A<B, A<=B, A>B and A>=B in IEEE order, with infinities and subnormals included.
- R5: For add (op_sel 2'b00) and subtract (op_sel 2'b01), the exponent field is the larger of the two biased exponents.
- R6: For add, the effective-operation bit is 1 when the operand signs differ and 0 when they match. For subtract, it is 1 when the signs match and 0 when they differ. For multiply it is 0.
- R7: For multiply (op_sel 2'b10, and 2'b11 treated the same way), the exponent field is the sum of the two biased exponents when that sum is at most 0x7FF, and 0x7FF otherwise.
- R8: For multiply, the sign is the XOR of the operand signs.
- R9: For add and subtract, the sign is that of the operand with the larger magnitude, where magnitude is bits 62..0 compared unsigned and B's sign is inverted for subtract. When the magnitudes are equal, the sign is A's sign if the effective signs match and 0 (exact cancellation) if they differ.
- R10: With the output register enabled, flags_o is zero while rst_n is low. After reset, flags_o shows the word for the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | Operand A, IEEE double |
| op_b | input | 64 | Operand B, IEEE double |
| op_sel | input | 2 | 00 add, 01 subtract, 10 or 11 multiply |
| flags_o | output | 64 | Packed flags word |

## Verification
On every cycle, the assertions check the structural rules of the word: reserved bits are zero, eq and neq exclude each other, a NaN forces the unordered pattern, exactly one of lt, eq and gt holds for ordered operands, the multiply exponent saturates, and the effective-operation bit is clear for multiply. Numeric correctness cannot be shown that way. The ordering across signed zeros, subnormals and infinities, the maximum-exponent choice, and the sign chosen under cancellation only show up in the bench. The bench sweeps every pair of a set of special and ordinary doubles under every op_sel code, and takes its reference ordering from real-number comparison.

// File: rtl/fpflag_pkg.sv
// Package: shared operation codes and bit positions of the flags word.
// Assumes the exponent field starts at bit 7 and that the fixed bit
// positions below are decoded by the downstream mantissa stages.
package fpflag_pkg;

    typedef enum logic [1:0] {
        FPF_ADD     = 2'b00,
        FPF_SUB     = 2'b01,
        FPF_MUL     = 2'b10,
        FPF_MUL_ALT = 2'b11
    } fpf_op_e;

    localparam int FPF_EXP_LSB  = 7;
    localparam int FPF_SIGN_BIT = 20;
    localparam int FPF_ASUB_BIT = 21;
    localparam int FPF_UNORD    = 25;
    localparam int FPF_LT       = 26;
    localparam int FPF_LE       = 27;
    localparam int FPF_GT       = 28;
    localparam int FPF_GE       = 29;
    localparam int FPF_EQ       = 30;
    localparam int FPF_NEQ      = 31;

endpackage

// File: rtl/fpflag_cmp.sv
// Module: fpflag_cmp
// Derives the seven IEEE comparison predicates of A against B, plus
// magnitude relations reused by the sign logic. Purely combinational.
// Assumes IEEE layout: sign at MSB, then EXP_W exponent, FRAC_W fraction.
module fpflag_cmp #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int MAG_W = W - 1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         unord_o,
    output logic         lt_o,
    output logic         le_o,
    output logic         gt_o,
    output logic         ge_o,
    output logic         eq_o,
    output logic         neq_o,
    output logic         mag_a_gt_o,
    output logic         mag_eq_o
);

    logic [1:0] is_nan;
    logic [1:0] is_zero;
    logic [1:0] sgn;
    logic [MAG_W-1:0] mag [2];

    // Per-operand classification: NaN, zero, sign and magnitude.
    for (genvar i = 0; i < 2; i++) begin : g_class
        logic [W-1:0] v;
        assign v          = (i == 0) ? a_i : b_i;
        assign sgn[i]     = v[W-1];
        assign mag[i]     = v[MAG_W-1:0];
        assign is_nan[i]  = (&v[W-2:FRAC_W]) & (|v[FRAC_W-1:0]);
        assign is_zero[i] = ~|v[MAG_W-1:0];
    end

    logic both_zero;
    logic same_val;
    logic a_below;

    // Ordering of A against B from signs and magnitudes.
    always_comb begin
        both_zero = is_zero[0] & is_zero[1];
        same_val  = (a_i == b_i) | both_zero;
        unique case ({sgn[0], sgn[1]})
            2'b10:   a_below = ~both_zero;
            2'b01:   a_below = 1'b0;
            2'b00:   a_below = mag[0] < mag[1];
            default: a_below = mag[0] > mag[1];
        endcase
    end

    // Predicate outputs; any NaN suppresses every ordered relation.
    always_comb begin
        unord_o = |is_nan;
        eq_o    = ~unord_o & same_val;
        lt_o    = ~unord_o & a_below;
        gt_o    = ~unord_o & ~a_below & ~same_val;
        le_o    = lt_o | eq_o;
        ge_o    = gt_o | eq_o;
        neq_o   = ~eq_o;
    end

    // Magnitude relations for the add/subtract sign choice.
    always_comb begin
        mag_a_gt_o = mag[0] > mag[1];
        mag_eq_o   = mag[0] == mag[1];
    end

endmodule

// File: rtl/fpflag_exp.sv
// Module: fpflag_exp
// Builds the preliminary exponent, result sign and effective add/sub bit
// from operand signs, exponents and the magnitude relations from the
// comparator. Purely combinational; op codes come from fpflag_pkg.
module fpflag_exp
    import fpflag_pkg::*;
#(
    parameter int EXP_W = 11,
    localparam int SUM_W = EXP_W + 1,
    localparam logic [SUM_W-1:0] EXP_MAX = {1'b0, {EXP_W{1'b1}}}
) (
    input  logic             sa_i,
    input  logic             sb_i,
    input  logic [EXP_W-1:0] ea_i,
    input  logic [EXP_W-1:0] eb_i,
    input  fpf_op_e          op_i,
    input  logic             mag_a_gt_i,
    input  logic             mag_eq_i,
    output logic [EXP_W-1:0] exp_o,
    output logic             sign_o,
    output logic             asub_o
);

    logic             is_mul;
    logic             is_sub;
    logic             sb_eff;
    logic [SUM_W-1:0] exp_sum;
    logic [EXP_W-1:0] exp_big;
    logic             as_sign;

    // Decode operation and form the candidate exponents.
    always_comb begin
        is_mul  = (op_i == FPF_MUL) || (op_i == FPF_MUL_ALT);
        is_sub  = (op_i == FPF_SUB);
        sb_eff  = sb_i ^ is_sub;
        exp_sum = {1'b0, ea_i} + {1'b0, eb_i};
        exp_big = (ea_i > eb_i) ? ea_i : eb_i;
    end

    // Sign for add/subtract: larger magnitude wins, cancellation is positive.
    always_comb begin
        if (mag_a_gt_i)
            as_sign = sa_i;
        else if (mag_eq_i)
            as_sign = (sa_i == sb_eff) ? sa_i : 1'b0;
        else
            as_sign = sb_eff;
    end

    // Select outputs by operation class.
    always_comb begin
        if (is_mul) begin
            exp_o  = (exp_sum > EXP_MAX) ? EXP_MAX[EXP_W-1:0] : exp_sum[EXP_W-1:0];
            sign_o = sa_i ^ sb_i;
            asub_o = 1'b0;
        end else begin
            exp_o  = exp_big;
            sign_o = as_sign;
            asub_o = sa_i ^ sb_eff;
        end
    end

endmodule

// File: rtl/fpflag_gen.sv
// Module: fpflag_gen (top)
// Packs comparison predicates, sign, exponent and effective-operation bit
// into a 64-bit flags word. REG_OUT=1 adds one output register with a
// synchronous active-low reset; REG_OUT=0 leaves the path combinational.
// Assumes FLAG_W is wide enough for the fixed positions in fpflag_pkg.
module fpflag_gen
    import fpflag_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int FLAG_W  = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [1:0]        op_sel,
    output logic [FLAG_W-1:0] flags_o
);

    localparam int EXP_MSB = FPF_EXP_LSB + EXP_W - 1;

    logic unord, lt, le, gt, ge, eq, neq, mag_a_gt, mag_eq;
    logic [EXP_W-1:0] exp_f;
    logic sign_f, asub_f;
    logic [FLAG_W-1:0] word_c;

    fpflag_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
        .a_i(op_a), .b_i(op_b),
        .unord_o(unord), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge),
        .eq_o(eq), .neq_o(neq), .mag_a_gt_o(mag_a_gt), .mag_eq_o(mag_eq)
    );

    fpflag_exp #(.EXP_W(EXP_W)) u_exp (
        .sa_i(op_a[W-1]), .sb_i(op_b[W-1]),
        .ea_i(op_a[W-2:FRAC_W]), .eb_i(op_b[W-2:FRAC_W]),
        .op_i(fpf_op_e'(op_sel)),
        .mag_a_gt_i(mag_a_gt), .mag_eq_i(mag_eq),
        .exp_o(exp_f), .sign_o(sign_f), .asub_o(asub_f)
    );

    // Assemble the word; unlisted bits stay zero.
    always_comb begin
        word_c                         = '0;
        word_c[EXP_MSB:FPF_EXP_LSB]    = exp_f;
        word_c[FPF_SIGN_BIT]           = sign_f;
        word_c[FPF_ASUB_BIT]           = asub_f;
        word_c[FPF_UNORD]              = unord;
        word_c[FPF_LT]                 = lt;
        word_c[FPF_LE]                 = le;
        word_c[FPF_GT]                 = gt;
        word_c[FPF_GE]                 = ge;
        word_c[FPF_EQ]                 = eq;
        word_c[FPF_NEQ]                = neq;
    end

    if (REG_OUT) begin : g_reg
        logic [FLAG_W-1:0] word_q;

        // Output register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_c;
        end
        assign flags_o = word_q;

        localparam logic [FLAG_W-1:0] USED_MASK =
            (FLAG_W'(1) << FPF_NEQ) | (FLAG_W'(1) << FPF_EQ) |
            (FLAG_W'(1) << FPF_GE)  | (FLAG_W'(1) << FPF_GT) |
            (FLAG_W'(1) << FPF_LE)  | (FLAG_W'(1) << FPF_LT) |
            (FLAG_W'(1) << FPF_UNORD) | (FLAG_W'(1) << FPF_ASUB_BIT) |
            (FLAG_W'(1) << FPF_SIGN_BIT) |
            (((FLAG_W'(1) << EXP_W) - FLAG_W'(1)) << FPF_EXP_LSB);

        assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((flags_o & ~USED_MASK) == '0));

        assert_eq_neq_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (flags_o[FPF_EQ] ^ flags_o[FPF_NEQ]));

        assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (!flags_o[FPF_UNORD] ||
                      (flags_o[FPF_NEQ] && !flags_o[FPF_EQ] && !flags_o[FPF_LT] &&
                       !flags_o[FPF_LE] && !flags_o[FPF_GT] && !flags_o[FPF_GE])));

        assert_one_relation_R4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (flags_o[FPF_UNORD] ||
                      $countones({flags_o[FPF_LT], flags_o[FPF_EQ], flags_o[FPF_GT]}) == 1));

        assert_mul_no_asub_R6: assert property (@(posedge clk) disable iff (!rst_n)
            op_sel[1] |=> !flags_o[FPF_ASUB_BIT]);

        assert_mul_exp_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel[1] && (({1'b0, op_a[W-2:FRAC_W]} + {1'b0, op_b[W-2:FRAC_W]}) >
                           {1'b0, {EXP_W{1'b1}}}))
            |=> (flags_o[EXP_MSB:FPF_EXP_LSB] == {EXP_W{1'b1}}));

        assert_reset_clear_R10: assert property (@(posedge clk)
            !rst_n |=> (flags_o == '0));
    end else begin : g_comb
        assign flags_o = word_c;
    end

endmodule

// File: tb/fpflag_gen_tb.sv
module fpflag_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  op_sel = 2'b00;
    logic [63:0] flags_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpflag_gen u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .op_sel(op_sel), .flags_o(flags_o)
    );

    function automatic logic [63:0] pick(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h8000_0000_0000_0000;
            2:  return 64'h3FF0_0000_0000_0000;
            3:  return 64'hBFF0_0000_0000_0000;
            4:  return 64'h4000_0000_0000_0000;
            5:  return 64'hC000_0000_0000_0000;
            6:  return 64'h3FF8_0000_0000_0000;
            7:  return 64'h7FF0_0000_0000_0000;
            8:  return 64'hFFF0_0000_0000_0000;
            9:  return 64'h7FF8_0000_0000_0000;
            10: return 64'hFFF0_0000_0000_0001;
            11: return 64'h0000_0000_0000_0001;
            12: return 64'h7FEF_FFFF_FFFF_FFFF;
            13: return 64'h5000_0000_0000_0000;
            14: return 64'hBFF0_0000_0000_0001;
            default: return 64'hD000_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] op);
        logic [63:0] w;
        int ea, eb, sum;
        bit na, nb, sbe;
        real ra, rb;
        w  = '0;
        ea = int'(a[62:52]);
        eb = int'(b[62:52]);
        na = (ea == 2047) && (a[51:0] != 0);
        nb = (eb == 2047) && (b[51:0] != 0);
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (na || nb) begin
            w[25] = 1'b1;
            w[31] = 1'b1;
        end else begin
            w[30] = (ra == rb);
            w[31] = !(ra == rb);
            w[26] = (ra < rb);
            w[27] = (ra <= rb);
            w[28] = (ra > rb);
            w[29] = (ra >= rb);
        end
        if (op[1]) begin
            sum = ea + eb;
            w[17:7] = (sum > 2047) ? 11'h7FF : sum[10:0];
            w[20] = a[63] ^ b[63];
        end else begin
            w[17:7] = (ea > eb) ? a[62:52] : b[62:52];
            sbe = b[63] ^ (op == 2'b01);
            w[21] = (a[63] != sbe);
            if (a[62:0] > b[62:0])      w[20] = a[63];
            else if (b[62:0] > a[62:0]) w[20] = sbe;
            else                        w[20] = (a[63] == sbe) ? a[63] : 1'b0;
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (a=%h b=%h op=%0d)",
                     req, act, exp, op_a, op_b, op_sel);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op);
        logic [63:0] e;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op;
        @(posedge clk);
        #1;
        e = model(a, b, op);
        // R1: reserved bits zero
        chk((flags_o & ~64'h0000_0000_FE33_FF80) == 0, "R1", flags_o, e);
        // R2/R3/R4: predicate field bits 31..25
        chk(flags_o[31:25] == e[31:25], e[25] ? "R3" : (e[30] ? "R2" : "R4"),
            {57'd0, flags_o[31:25]}, {57'd0, e[31:25]});
        // R5 for add/sub, R7 for multiply: exponent bits 17..7
        chk(flags_o[17:7] == e[17:7], op[1] ? "R7" : "R5",
            {53'd0, flags_o[17:7]}, {53'd0, e[17:7]});
        // R8 for multiply, R9 for add/sub: sign at bit 20
        chk(flags_o[20] == e[20], op[1] ? "R8" : "R9",
            {63'd0, flags_o[20]}, {63'd0, e[20]});
        // R6: effective-operation bit at 21
        chk(flags_o[21] == e[21], "R6", {63'd0, flags_o[21]}, {63'd0, e[21]});
    endtask

    initial begin
        // R10: reset clears the output even with active inputs
        op_a = 64'h7FF8_0000_0000_0000; op_b = 64'hBFF0_0000_0000_0000; op_sel = 2'b10;
        repeat (3) @(posedge clk);
        #1;
        chk(flags_o == 64'd0, "R10", flags_o, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: one-cycle latency, value reflects the last sampled inputs
        @(posedge clk);
        #1;
        chk(flags_o == model(op_a, op_b, op_sel), "R10", flags_o, model(op_a, op_b, op_sel));
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    apply(pick(i), pick(j), 2'(op));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule